// File: doc/BRIEF.md
# Block Address Translation Lookup

This unit translates a 32-bit logical address through a small set of block-translation entries. It keeps one entry array for instruction fetches and a second for data accesses. A request names its side, its privilege level, whether it is a write, and the logical address. One cycle later the unit returns four things: whether an entry matched, the protection code of that entry, the translated physical address, and whether the access breaks the protection rules. When a protection fault occurs, the unit also captures a fault status word and the faulting logical address. Both stay held until the next fault.

Software or a neighbouring controller loads the entries through a single-entry write port. Each write carries the eligibility bits, the address mask, the block index, the physical upper bits and the protection code. Page-table translation and the handling of the fault itself are done elsewhere.

A four-state result machine (`S_IDLE`, `S_MISS`, `S_HIT`, `S_FAULT`) holds the kind of result for the previous cycle. At every clock edge the next state is chosen as follows:
- If no request is present, the machine goes to `S_IDLE`.
- If a request finds no matching entry, it goes to `S_MISS`.
- If a request matches an entry and breaks its protection, it goes to `S_FAULT`.
- If a request matches an entry without breaking its protection, it goes to `S_HIT`.

Any state can move to any of the four. The response flags are decoded from the current state.

Top module: `blt_lookup`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_status` and `rsp_fault_addr` are all zero. Every entry has zero eligibility bits, so no request can hit until entries are written.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low after a cycle without a request. The other response outputs in that cycle belong to that request.
- R3: The request eligibility mask is {~req_user, req_user}. Bit 1 stands for supervisor and bit 0 stands for user. An entry matches when (its eligibility bits AND that mask) is nonzero and (req_addr AND its mask) equals its block index.
- R4: The four entries of an array are searched from index 0 upward, and the lowest-indexed matching entry is used.
- R5: On a hit, `rsp_paddr` is the entry's physical bits ORed with (req_addr AND NOT mask), and `rsp_prot` is the entry's 2-bit protection code.
- R6: `req_side` and `wr_side` select the array: 0 is the instruction array and 1 is the data array. A request searches only the array it selects.
- R7: On a miss, `rsp_hit`, `rsp_fault`, `rsp_paddr` and `rsp_prot` are all zero.
- R8: `rsp_fault` is high only on a hit whose protection code is 0, or whose protection bit 0 is 1 while `req_write` is 1.
- R9: On a fault, `rsp_status` becomes 0x08000000 with bit 25 set to `req_write`, and `rsp_fault_addr` becomes req_addr. Both hold their values until the next fault.
- R10: A write with `wr_en` replaces the entry at (`wr_side`, `wr_idx`). A lookup in the same cycle uses the old contents, and the following lookup uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Array of the write: 0 instruction, 1 data |
| wr_idx | input | 2 | Entry index of the write |
| wr_access | input | 2 | Eligibility bits: bit 1 supervisor, bit 0 user |
| wr_mask | input | 32 | Address mask of the entry |
| wr_bindex | input | 32 | Block index compared against the masked address |
| wr_phys | input | 32 | Physical upper bits |
| wr_prot | input | 2 | Protection code |
| req_valid | input | 1 | Lookup request |
| req_side | input | 1 | Array of the request: 0 instruction, 1 data |
| req_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| req_write | input | 1 | 1 for a write access |
| req_addr | input | 32 | Logical address |
| rsp_valid | output | 1 | Result present for the previous cycle's request |
| rsp_hit | output | 1 | An entry matched |
| rsp_prot | output | 2 | Protection code of the matched entry |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Protection fault |
| rsp_status | output | 32 | Status word of the last fault |
| rsp_fault_addr | output | 32 | Logical address of the last fault |

## Verification
The tests use overlapping entries, one supervisor-only and one open to both levels, so that supervisor and user requests to the same address resolve differently. This separates the lowest-index priority rule from the eligibility-mask rule. They issue requests with the same address to each array, to show that the side select keeps the two arrays apart. They also exercise three protection cases: a zero protection code, a read-only code on a write, and a writable code on a write. This shows which combinations fault, which status bit 25 results, and that the captured status holds through accesses that do not fault. A write issued together with a lookup of the same entry shows that the first result uses the old contents and the next result uses the new ones.

// File: rtl/blt_pkg.sv
package blt_pkg;
    localparam int ADDR_W = 32;
    localparam int ACC_W  = 2;
    localparam int PROT_W = 2;

    // fault status word: fixed protection-violation bit plus write flag
    localparam logic [ADDR_W-1:0] FAULT_BASE = 32'h0800_0000;
    localparam int                FAULT_WR_BIT = 25;

    typedef struct packed {
        logic [ACC_W-1:0]  access;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] bindex;
        logic [ADDR_W-1:0] phys;
        logic [PROT_W-1:0] prot;
    } blt_entry_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MISS,
        S_HIT,
        S_FAULT
    } blt_state_t;
endpackage

// File: rtl/blt_bank.sv
module blt_bank
    import blt_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  blt_entry_t                  wr_entry,
    output blt_entry_t [N_ENTRIES-1:0]  entries_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entries_o <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    entries_o[i] <= wr_entry;
                end
            end
        end
    end
endmodule

// File: rtl/blt_match.sv
module blt_match
    import blt_pkg::*;
#(
    parameter int N_ENTRIES = 4
) (
    input  blt_entry_t [N_ENTRIES-1:0] entries_i,
    input  logic [ACC_W-1:0]           req_acc,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       hit,
    output blt_entry_t                 hit_entry
);
    logic [N_ENTRIES-1:0] match_vec;

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = (|(entries_i[g].access & req_acc)) &&
                                  ((addr & entries_i[g].mask) == entries_i[g].bindex);
        end
    endgenerate

    // descending scan so the lowest matching index is the last one written
    always_comb begin
        hit       = 1'b0;
        hit_entry = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit       = 1'b1;
                hit_entry = entries_i[i];
            end
        end
    end
endmodule

// File: rtl/blt_prot.sv
module blt_prot
    import blt_pkg::*;
(
    input  logic              hit,
    input  logic [PROT_W-1:0] prot,
    input  logic              is_write,
    output logic              fault,
    output logic [ADDR_W-1:0] status
);
    logic no_access;
    logic ro_violation;

    assign no_access    = (prot == '0);
    assign ro_violation = prot[0] && is_write;
    assign fault        = hit && (no_access || ro_violation);

    always_comb begin
        status               = FAULT_BASE;
        status[FAULT_WR_BIT] = is_write;
    end
endmodule

// File: rtl/blt_lookup.sv
module blt_lookup
    import blt_pkg::*;
#(
    parameter  int N_ENTRIES = 4,
    localparam int IDX_W     = $clog2(N_ENTRIES),
    localparam int N_SIDES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ACC_W-1:0]  wr_access,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] wr_bindex,
    input  logic [ADDR_W-1:0] wr_phys,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic              req_valid,
    input  logic              req_side,
    input  logic              req_user,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PROT_W-1:0] rsp_prot,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_status,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    blt_entry_t                 wr_entry;
    blt_entry_t [N_ENTRIES-1:0] bank_q [N_SIDES];
    blt_entry_t [N_ENTRIES-1:0] sel_entries;
    blt_entry_t                 hit_entry;
    logic [ACC_W-1:0]           req_acc;
    logic                       lk_hit;
    logic                       lk_fault;
    logic [ADDR_W-1:0]          lk_status;
    logic [ADDR_W-1:0]          lk_paddr;

    blt_state_t state_q, state_d;

    logic [ADDR_W-1:0] paddr_q;
    logic [PROT_W-1:0] prot_q;
    logic [ADDR_W-1:0] status_q;
    logic [ADDR_W-1:0] faddr_q;

    assign wr_entry = '{access: wr_access, mask: wr_mask, bindex: wr_bindex,
                        phys: wr_phys, prot: wr_prot};

    // one storage bank per side, written only when its side is addressed
    generate
        for (genvar s = 0; s < N_SIDES; s++) begin : g_side
            blt_bank #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_en && (wr_side == 1'(s))),
                .wr_idx    (wr_idx),
                .wr_entry  (wr_entry),
                .entries_o (bank_q[s])
            );
        end
    endgenerate

    assign sel_entries = req_side ? bank_q[1] : bank_q[0];

    // supervisor in bit 1, user in bit 0; exactly one set
    assign req_acc = {~req_user, req_user};

    blt_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .entries_i (sel_entries),
        .req_acc   (req_acc),
        .addr      (req_addr),
        .hit       (lk_hit),
        .hit_entry (hit_entry)
    );

    assign lk_paddr = hit_entry.phys | (req_addr & ~hit_entry.mask);

    blt_prot u_prot (
        .hit      (lk_hit),
        .prot     (hit_entry.prot),
        .is_write (req_write),
        .fault    (lk_fault),
        .status   (lk_status)
    );

    // next-state selection
    always_comb begin
        if (!req_valid) begin
            state_d = S_IDLE;
        end else if (!lk_hit) begin
            state_d = S_MISS;
        end else if (lk_fault) begin
            state_d = S_FAULT;
        end else begin
            state_d = S_HIT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            prot_q   <= '0;
            status_q <= '0;
            faddr_q  <= '0;
        end else begin
            if (req_valid) begin
                paddr_q <= lk_hit ? lk_paddr : '0;
                prot_q  <= lk_hit ? hit_entry.prot : '0;
            end
            if (req_valid && lk_fault) begin
                status_q <= lk_status;
                faddr_q  <= req_addr;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_MISS: begin
                rsp_valid = 1'b1;
            end
            S_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            S_FAULT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_fault = 1'b1;
            end
        endcase
    end

    assign rsp_paddr      = paddr_q;
    assign rsp_prot       = prot_q;
    assign rsp_status     = status_q;
    assign rsp_fault_addr = faddr_q;
endmodule

// File: rtl/blt_lookup_chk.sv
module blt_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [1:0]  rsp_prot,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [31:0] rsp_status,
    input logic [31:0] rsp_fault_addr
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_miss_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_fault && rsp_paddr == 32'h0 && rsp_prot == 2'b00));

    assert_fault_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_valid));

    assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && rsp_prot != 2'b00) |-> ($past(req_write) && rsp_prot[0]));

    assert_fault_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_status == {4'h0, 1'b1, 1'b0, $past(req_write), 25'h0}));

    assert_fault_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_fault_addr == $past(req_addr)));

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> ($stable(rsp_status) && $stable(rsp_fault_addr)));
endmodule

bind blt_lookup blt_lookup_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_prot       (rsp_prot),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault),
    .rsp_status     (rsp_status),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/tb_blt_lookup.sv
`timescale 1ns/1ps
module tb_blt_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_side = 1'b0;
    logic [1:0]  wr_idx = '0, wr_access = '0, wr_prot = '0;
    logic [31:0] wr_mask = '0, wr_bindex = '0, wr_phys = '0;
    logic        req_valid = 1'b0, req_side = 1'b0, req_user = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [1:0]  rsp_prot;
    logic [31:0] rsp_paddr, rsp_status, rsp_fault_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blt_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx), .wr_access(wr_access),
        .wr_mask(wr_mask), .wr_bindex(wr_bindex), .wr_phys(wr_phys), .wr_prot(wr_prot),
        .req_valid(req_valid), .req_side(req_side), .req_user(req_user),
        .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_prot(rsp_prot),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rsp_fault_addr(rsp_fault_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic write_entry(input logic side, input logic [1:0] idx, input logic [1:0] acc,
                               input logic [31:0] mask, input logic [31:0] bi,
                               input logic [31:0] ph, input logic [1:0] pr);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_access = acc;
        wr_mask = mask; wr_bindex = bi; wr_phys = ph; wr_prot = pr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // request applied for one cycle; response sampled at the following falling edge
    task automatic lookup(input logic side, input logic user, input logic wr, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_side = side; req_user = user; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] pa, input logic [1:0] pr,
                              input logic flt);
        check(req, "valid", 32'(rsp_valid), 32'd1);
        check(req, "hit", 32'(rsp_hit), 32'd1);
        check(req, "paddr", rsp_paddr, pa);
        check(req, "prot", 32'(rsp_prot), 32'(pr));
        check(req, "fault", 32'(rsp_fault), 32'(flt));
    endtask

    task automatic expect_miss(input string req);
        check(req, "valid", 32'(rsp_valid), 32'd1);
        check(req, "hit", 32'(rsp_hit), 32'd0);
        check(req, "fault", 32'(rsp_fault), 32'd0);
        check(req, "paddr", rsp_paddr, 32'h0);
        check(req, "prot", 32'(rsp_prot), 32'h0);
    endtask

    task automatic t_reset;
        check("R1", "valid", 32'(rsp_valid), 32'd0);
        check("R1", "hit", 32'(rsp_hit), 32'd0);
        check("R1", "fault", 32'(rsp_fault), 32'd0);
        check("R1", "status", rsp_status, 32'h0);
        check("R1", "fault_addr", rsp_fault_addr, 32'h0);
        lookup(1'b1, 1'b0, 1'b0, 32'h1234_5678);
        expect_miss("R1");
        lookup(1'b0, 1'b1, 1'b0, 32'h0000_0000);
        expect_miss("R1");
    endtask

    task automatic t_load;
        write_entry(1'b1, 2'd0, 2'b10, 32'hF000_0000, 32'h1000_0000, 32'h8000_0000, 2'b10);
        write_entry(1'b1, 2'd1, 2'b11, 32'hFFF0_0000, 32'h1230_0000, 32'h4560_0000, 2'b01);
        write_entry(1'b1, 2'd2, 2'b01, 32'hFF00_0000, 32'h2000_0000, 32'h3000_0000, 2'b00);
        write_entry(1'b0, 2'd0, 2'b11, 32'hF000_0000, 32'h1000_0000, 32'hC000_0000, 2'b10);
    endtask

    task automatic t_translate;
        lookup(1'b1, 1'b0, 1'b0, 32'h1ABC_DEF0);
        expect_hit("R5", 32'h8ABC_DEF0, 2'b10, 1'b0);
    endtask

    task automatic t_latency;
        lookup(1'b1, 1'b0, 1'b0, 32'h1ABC_DEF0);
        check("R2", "valid after request", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        check("R2", "valid after idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_priority;
        lookup(1'b1, 1'b0, 1'b0, 32'h1234_5678);
        expect_hit("R4", 32'h8234_5678, 2'b10, 1'b0);
    endtask

    task automatic t_privilege;
        lookup(1'b1, 1'b1, 1'b0, 32'h1234_5678);
        expect_hit("R3", 32'h4564_5678, 2'b01, 1'b0);
        lookup(1'b1, 1'b1, 1'b0, 32'h1ABC_DEF0);
        expect_miss("R3");
    endtask

    task automatic t_side;
        lookup(1'b0, 1'b0, 1'b0, 32'h1234_5678);
        expect_hit("R6", 32'hC234_5678, 2'b10, 1'b0);
        lookup(1'b0, 1'b1, 1'b0, 32'h20AB_CDEF);
        expect_miss("R6");
    endtask

    task automatic t_miss;
        lookup(1'b1, 1'b0, 1'b0, 32'h5000_0000);
        expect_miss("R7");
    endtask

    task automatic t_fault;
        lookup(1'b1, 1'b1, 1'b0, 32'h20AB_CDEF);
        expect_hit("R8", 32'h30AB_CDEF, 2'b00, 1'b1);
        check("R9", "status noaccess", rsp_status, 32'h0800_0000);
        check("R9", "fault_addr", rsp_fault_addr, 32'h20AB_CDEF);
        lookup(1'b1, 1'b1, 1'b1, 32'h1234_5678);
        expect_hit("R8", 32'h4564_5678, 2'b01, 1'b1);
        check("R9", "status write", rsp_status, 32'h0A00_0000);
        check("R9", "fault_addr", rsp_fault_addr, 32'h1234_5678);
        lookup(1'b1, 1'b0, 1'b1, 32'h1ABC_DEF0);
        expect_hit("R8", 32'h8ABC_DEF0, 2'b10, 1'b0);
        check("R9", "status held", rsp_status, 32'h0A00_0000);
        check("R9", "fault_addr held", rsp_fault_addr, 32'h1234_5678);
    endtask

    task automatic t_write_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_side = 1'b1; wr_idx = 2'd3; wr_access = 2'b11;
        wr_mask = 32'hF000_0000; wr_bindex = 32'h7000_0000; wr_phys = 32'h9000_0000;
        wr_prot = 2'b10;
        req_valid = 1'b1; req_side = 1'b1; req_user = 1'b0; req_write = 1'b0;
        req_addr = 32'h7000_0010;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_miss("R10");
        lookup(1'b1, 1'b0, 1'b0, 32'h7000_0010);
        expect_hit("R10", 32'h9000_0010, 2'b10, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_translate();
        t_latency();
        t_priority();
        t_privilege();
        t_side();
        t_miss();
        t_fault();
        t_write_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before the tests completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule